// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits on the host side of a byte-wide parallel EEPROM that has SRAM-like strobes: active-low chip enable, write enable and output enable. A single start command gives a base address and a byte count. The controller then takes the bytes from a valid/ready stream and issues them as back-to-back byte writes, all inside one 64-byte page. Every strobe width is counted in clock cycles, so the spacing between writes never lets the device's byte-load window close before the burst is over.

After the last byte is written, the controller reads that same address again and again. While the device is still programming, the device returns bit 7 inverted. Once the read value equals the byte that was written, the controller reports completion. If the stream stops feeding bytes for close to a full load window, the burst is cut short and polling starts at once. A polling phase that runs too long ends with a timeout flag. A request whose bytes would not fit inside one page is refused before any strobe moves.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are high, and `mem_dq_oe`, `s_ready`, `busy`, `done`, `err_range` and `err_timeout` are low.
- R2: An accepted start raises `busy` on the next cycle. `busy` stays high until the cycle in which `done` or `err_timeout` pulses. `busy` is high whenever `mem_ce_n` is low.
- R3: A start is refused when `byte_count` is 0, or when the offset in `base_addr[5:0]` plus `byte_count` is greater than 64. A refused start gives a one-cycle `err_range` pulse. It produces no write strobe and leaves `busy` low.
- R4: Each byte accepted from the stream produces exactly one write strobe. The strobe holds `mem_we_n` low for exactly WE_LOW cycles, with `mem_ce_n` low and `mem_oe_n` high. `mem_dq_oe` is high and the byte is on `mem_dq_o` at the rising edge of `mem_we_n`. Between two strobes, `mem_we_n` stays high for at least WE_HIGH cycles.
- R5: The offset `mem_addr[5:0]` of the k-th strobe is the base offset plus k. `mem_addr[14:6]` equals the base page on every strobe of a burst. The bytes are written in stream order.
- R6: Two successive falling edges of `mem_we_n` in one burst are never more than LOAD_WIN cycles apart.
- R7: Suppose no byte is offered while the load window is about to close and at least one byte has been written. The burst then ends with fewer strobes than requested, polling starts, and `s_ready` is low from then on.
- R8: Polling reads the last written address with `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high. `done` pulses only after a read returns the written byte exactly, which needs bit 7 to have stopped reading inverted.
- R9: If no read matches within POLL_TIMEOUT cycles of the start of polling, `err_timeout` pulses for one cycle, `busy` falls and `done` does not pulse.
- R10: `mem_dq_oe` is high only while `mem_oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a burst (sampled while idle) |
| base_addr | input | 15 | Page number in bits 14:6, first byte offset in bits 5:0 |
| byte_count | input | 7 | Number of bytes to write, 1 to 64 |
| s_valid | input | 1 | Stream byte present |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Controller takes the stream byte this cycle |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_addr | output | 15 | Device address |
| mem_dq_o | output | 8 | Data driven toward the device |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_i | input | 8 | Data read from the device |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse: programming confirmed |
| err_range | output | 1 | One-cycle pulse: request refused |
| err_timeout | output | 1 | One-cycle pulse: polling gave up |

## Verification
Random bursts use random pages, offsets and lengths, random stream gaps and random device busy times. These show that the addresses increment, the page holds and the data lands in order, whatever the alignment. Directed single-byte writes with bit 7 set and with bit 7 clear show that completion depends on the inverted bit returning to its true value, and not merely on any read. A full 64-byte page and a last-offset single byte probe both ends of the page. Offsets and counts that overrun the page are refused and produce no strobe. A deliberately stalled stream shows the early end of a burst. A device that never finishes shows the timeout path, which ends without completion.

// File: rtl/eepw_pkg.sv
package eepw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_WLO,
        ST_WHI,
        ST_RD,
        ST_GAP
    } eepw_state_e;
endpackage

// File: rtl/eepw_down_timer.sv
module eepw_down_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/eepw_page_check.sv
module eepw_page_check #(
    parameter int OFF_W      = 6,
    parameter int PAGE_BYTES = 64
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [OFF_W:0]   count,
    output logic             fits
);
    logic [OFF_W+1:0] span;

    always_comb begin
        span = {2'b00, offset} + {1'b0, count};
        fits = (count != '0) && (span <= (OFF_W+2)'(PAGE_BYTES));
    end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int PAGE_BYTES   = 64,
    parameter int WE_LOW       = 3,
    parameter int WE_HIGH      = 2,
    parameter int RD_DLY       = 3,
    parameter int LOAD_WIN     = 7500,
    parameter int POLL_TIMEOUT = 500000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [ADDR_W-1:0]           base_addr,
    input  logic [$clog2(PAGE_BYTES):0] byte_count,
    input  logic                        s_valid,
    input  logic [DATA_W-1:0]           s_data,
    output logic                        s_ready,
    output logic                        mem_ce_n,
    output logic                        mem_we_n,
    output logic                        mem_oe_n,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [DATA_W-1:0]           mem_dq_o,
    output logic                        mem_dq_oe,
    input  logic [DATA_W-1:0]           mem_dq_i,
    output logic                        busy,
    output logic                        done,
    output logic                        err_range,
    output logic                        err_timeout
);
    import eepw_pkg::*;

    localparam int OFF_W    = $clog2(PAGE_BYTES);
    localparam int PAGE_W   = ADDR_W - OFF_W;
    localparam int CNT_W    = OFF_W + 1;
    localparam int STRB_MAX = (WE_LOW > WE_HIGH) ? ((WE_LOW > RD_DLY) ? WE_LOW : RD_DLY)
                                                 : ((WE_HIGH > RD_DLY) ? WE_HIGH : RD_DLY);
    localparam int STRB_W   = $clog2(STRB_MAX + 1);
    localparam int WIN_W    = $clog2(LOAD_WIN + 1);
    localparam int TO_W     = $clog2(POLL_TIMEOUT + 1);

    typedef struct packed {
        eepw_state_e       st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic [CNT_W-1:0]  rem;
        logic [DATA_W-1:0] data;
        logic              wrote;
        logic              done;
        logic              err_range;
        logic              err_to;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              strb_load, strb_exp;
    logic [STRB_W-1:0] strb_val;
    logic              win_load, win_exp;
    logic              poll_load, poll_exp;
    logic              req_fits;

    eepw_page_check #(.OFF_W(OFF_W), .PAGE_BYTES(PAGE_BYTES)) u_fit (
        .offset (base_addr[OFF_W-1:0]),
        .count  (byte_count),
        .fits   (req_fits)
    );

    eepw_down_timer #(.W(STRB_W)) u_strobe (
        .clk(clk), .rst_n(rst_n), .load(strb_load), .load_val(strb_val), .expired(strb_exp)
    );

    eepw_down_timer #(.W(WIN_W)) u_window (
        .clk(clk), .rst_n(rst_n), .load(win_load),
        .load_val(WIN_W'(LOAD_WIN - 1)), .expired(win_exp)
    );

    eepw_down_timer #(.W(TO_W)) u_poll (
        .clk(clk), .rst_n(rst_n), .load(poll_load),
        .load_val(TO_W'(POLL_TIMEOUT - 1)), .expired(poll_exp)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.done      = 1'b0;
        ctl_d.err_range = 1'b0;
        ctl_d.err_to    = 1'b0;
        strb_load       = 1'b0;
        strb_val        = '0;
        win_load        = 1'b0;
        poll_load       = 1'b0;
        case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!req_fits) begin
                        ctl_d.err_range = 1'b1;
                    end else begin
                        ctl_d.st    = ST_WAIT;
                        ctl_d.page  = base_addr[ADDR_W-1:OFF_W];
                        ctl_d.off   = base_addr[OFF_W-1:0];
                        ctl_d.rem   = byte_count;
                        ctl_d.wrote = 1'b0;
                    end
                end
            end
            ST_WAIT: begin
                if (s_valid) begin
                    ctl_d.st    = ST_WLO;
                    ctl_d.data  = s_data;
                    ctl_d.rem   = ctl_q.rem - 1'b1;
                    ctl_d.wrote = 1'b1;
                    if (ctl_q.wrote) ctl_d.off = ctl_q.off + 1'b1;
                    strb_load   = 1'b1;
                    strb_val    = STRB_W'(WE_LOW - 1);
                    win_load    = 1'b1;
                end else if (ctl_q.wrote && win_exp) begin
                    ctl_d.st  = ST_RD;
                    strb_load = 1'b1;
                    strb_val  = STRB_W'(RD_DLY - 1);
                    poll_load = 1'b1;
                end
            end
            ST_WLO: begin
                if (strb_exp) begin
                    ctl_d.st  = ST_WHI;
                    strb_load = 1'b1;
                    strb_val  = STRB_W'(WE_HIGH - 1);
                end
            end
            ST_WHI: begin
                if (strb_exp) begin
                    if (ctl_q.rem == '0) begin
                        ctl_d.st  = ST_RD;
                        strb_load = 1'b1;
                        strb_val  = STRB_W'(RD_DLY - 1);
                        poll_load = 1'b1;
                    end else begin
                        ctl_d.st = ST_WAIT;
                    end
                end
            end
            ST_RD: begin
                if (poll_exp) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.err_to = 1'b1;
                end else if (strb_exp) begin
                    if (mem_dq_i == ctl_q.data) begin
                        ctl_d.st   = ST_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.st = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (poll_exp) begin
                    ctl_d.st     = ST_IDLE;
                    ctl_d.err_to = 1'b1;
                end else begin
                    ctl_d.st  = ST_RD;
                    strb_load = 1'b1;
                    strb_val  = STRB_W'(RD_DLY - 1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign s_ready     = (ctl_q.st == ST_WAIT);
    assign mem_we_n    = (ctl_q.st != ST_WLO);
    assign mem_oe_n    = (ctl_q.st != ST_RD);
    assign mem_ce_n    = !((ctl_q.st == ST_WLO) || (ctl_q.st == ST_WHI) || (ctl_q.st == ST_RD));
    assign mem_dq_oe   = (ctl_q.st == ST_WLO) || (ctl_q.st == ST_WHI);
    assign mem_addr    = {ctl_q.page, ctl_q.off};
    assign mem_dq_o    = ctl_q.data;
    assign busy        = (ctl_q.st != ST_IDLE);
    assign done        = ctl_q.done;
    assign err_range   = ctl_q.err_range;
    assign err_timeout = ctl_q.err_to;

    // Observation counters used only by the properties below
    logic              we_prev_q;
    logic [WIN_W:0]    gap_seen_q;
    logic [STRB_W:0]   lo_seen_q;
    logic [PAGE_W-1:0] pg_seen_q;
    logic              burst_seen_q;
    logic              we_fall;

    assign we_fall = we_prev_q && !mem_we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev_q    <= 1'b1;
            gap_seen_q   <= '0;
            lo_seen_q    <= '0;
            pg_seen_q    <= '0;
            burst_seen_q <= 1'b0;
        end else begin
            we_prev_q <= mem_we_n;
            lo_seen_q <= mem_we_n ? '0 : lo_seen_q + 1'b1;
            if (we_fall) begin
                gap_seen_q   <= (WIN_W+1)'(1);
                pg_seen_q    <= mem_addr[ADDR_W-1:OFF_W];
                burst_seen_q <= 1'b1;
            end else begin
                if (gap_seen_q != '1) gap_seen_q <= gap_seen_q + 1'b1;
                if (!busy) burst_seen_q <= 1'b0;
            end
        end
    end

    AST_BUS_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R10
    AST_SELECT_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> busy); // R2
    AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (lo_seen_q == (STRB_W+1)'(WE_LOW))); // R4
    AST_LOAD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && burst_seen_q) |-> (gap_seen_q <= (WIN_W+1)'(LOAD_WIN))); // R6
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (we_fall && burst_seen_q) |-> (mem_addr[ADDR_W-1:OFF_W] == pg_seen_q)); // R5
    AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_range |-> (!busy && mem_we_n)); // R3
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({done, err_timeout, err_range}) <= 1); // R9
endmodule

// File: tb/test_eeprom_page_writer.sv
module test_eeprom_page_writer;
    localparam int WE_LOW   = 3;
    localparam int WE_HIGH  = 2;
    localparam int RD_DLY   = 2;
    localparam int LOAD_WIN = 40;
    localparam int POLL_TO  = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [14:0] base_addr = '0;
    logic [6:0]  byte_count = '0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_o, mem_dq_i;
    logic        busy, done, err_range, err_timeout;

    always #10 clk = ~clk;

    eeprom_page_writer #(
        .WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH), .RD_DLY(RD_DLY),
        .LOAD_WIN(LOAD_WIN), .POLL_TIMEOUT(POLL_TO)
    ) i_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .byte_count(byte_count), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
        .mem_dq_i(mem_dq_i), .busy(busy), .done(done), .err_range(err_range),
        .err_timeout(err_timeout)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Device model: one page image, busy after each write strobe
    logic [7:0] pg [64];
    int busy_cnt = 0;
    int busy_cfg = 50;
    int wr_n = 0;
    logic [14:0] wr_addr [64];
    logic [7:0]  wr_data [64];
    logic prev_we = 1'b1;
    int lo_len = 0, hi_len = 100, since_fall = 0;
    bit burst_on = 0;
    int width_bad = 0, win_bad = 0, cont_bad = 0, busy_bad = 0;

    assign mem_dq_i = (!mem_ce_n && !mem_oe_n) ?
        ((busy_cnt != 0) ? {~pg[mem_addr[5:0]][7], pg[mem_addr[5:0]][6:0]} : pg[mem_addr[5:0]])
        : 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_cnt > 0) busy_cnt--;
            since_fall++;
            if (mem_dq_oe && !mem_oe_n) cont_bad++;
            if (!mem_ce_n && !busy) busy_bad++;
            if (!busy) burst_on = 0;
            if (prev_we && !mem_we_n) begin
                if (burst_on && since_fall > LOAD_WIN) win_bad++;
                if (burst_on && hi_len < WE_HIGH) width_bad++;
                if (mem_ce_n || !mem_oe_n) width_bad++;
                since_fall = 0;
                burst_on = 1;
                lo_len = 0;
            end
            if (!prev_we && mem_we_n) begin
                if (lo_len != WE_LOW || !mem_dq_oe) width_bad++;
                pg[mem_addr[5:0]] = mem_dq_o;
                if (wr_n < 64) begin
                    wr_addr[wr_n] = mem_addr;
                    wr_data[wr_n] = mem_dq_o;
                end
                wr_n++;
                busy_cnt = busy_cfg;
                hi_len = 0;
            end
            if (!mem_we_n) lo_len++;
            else hi_len++;
            prev_we = mem_we_n;
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic refuse(input int off, input int cnt);
        int wr0;
        wr0 = wr_n;
        base_addr = 15'(7 * 64 + off);
        byte_count = 7'(cnt);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(err_range == 1'b1, "R3 err_range pulse", err_range, 1);
        chk(busy == 1'b0, "R3 busy stays low", busy, 0);
        repeat (6) tick();
        chk(wr_n == wr0, "R3 no strobe", wr_n - wr0, 0);
    endtask

    task automatic run_burst(input int page, input int off, input int cnt, input int feed,
                             input int bcyc, input bit fix, input logic [7:0] fixv,
                             output bit got_done, output bit got_to);
        logic [7:0] exp_d [64];
        int mism;
        busy_cfg = bcyc;
        wr_n = 0;
        for (int i = 0; i < cnt; i++) exp_d[i] = fix ? fixv : 8'($urandom);
        base_addr = 15'(page * 64 + off);
        byte_count = 7'(cnt);
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", busy, 1);
        for (int i = 0; i < feed; i++) begin
            repeat ($urandom % 3) tick();
            s_valid = 1'b1;
            s_data = exp_d[i];
            for (int g = 0; g < 200 && !s_ready; g++) tick();
            tick();
            s_valid = 1'b0;
        end
        for (int k = 0; k < 4000 && !(done || err_timeout); k++) tick();
        got_done = done;
        got_to = err_timeout;
        if (got_done) chk(busy_cnt == 0, "R8 done only after device idle", busy_cnt, 0);
        chk(wr_n == feed, "R4 strobe count", wr_n, feed);
        mism = 0;
        for (int i = 0; i < feed && i < 64; i++) begin
            if (wr_addr[i] != 15'(page * 64 + off + i)) mism++;
            if (wr_data[i] != exp_d[i]) mism++;
        end
        chk(mism == 0, "R5 address/page/data order", mism, 0);
    endtask

    initial begin
        bit gd, gt;
        int pgn, off, cnt;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) pg[i] = 8'h00;
        repeat (3) tick();
        chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes idle", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
        chk({mem_dq_oe, s_ready, busy, done, err_range, err_timeout} == 6'b0, "R1 flags low",
            {mem_dq_oe, s_ready, busy, done, err_range, err_timeout}, 0);
        rst_n = 1'b1;
        repeat (2) tick();

        refuse(60, 8);
        refuse(0, 0);
        refuse(0, 65);
        refuse(63, 2);

        run_burst(3, 0, 64, 64, 60, 0, 8'h00, gd, gt);
        chk(gd && !gt, "R8 full page done", gd, 1);
        run_burst(511, 63, 1, 1, 30, 1, 8'h80, gd, gt);
        chk(gd && !gt, "R8 last offset, bit7 set", gd, 1);
        run_burst(0, 20, 1, 1, 45, 1, 8'h7F, gd, gt);
        chk(gd && !gt, "R8 bit7 clear", gd, 1);

        for (int r = 0; r < 12; r++) begin
            pgn = $urandom % 512;
            off = $urandom % 64;
            cnt = 1 + ($urandom % (64 - off));
            run_burst(pgn, off, cnt, cnt, 5 + ($urandom % 120), 0, 8'h00, gd, gt);
            chk(gd && !gt, "R8 random burst done", gd, 1);
            tick();
            chk(busy == 1'b0, "R2 busy falls after done", busy, 0);
        end

        run_burst(9, 10, 20, 5, 40, 0, 8'h00, gd, gt);
        chk(gd && !gt, "R7 stalled burst completes", gd, 1);
        chk(s_ready == 1'b0, "R7 no more bytes requested", s_ready, 0);

        run_burst(5, 4, 3, 3, 1000, 0, 8'h00, gd, gt);
        chk(gt && !gd, "R9 timeout without done", gt, 1);
        tick();
        chk(busy == 1'b0, "R9 busy falls on timeout", busy, 0);
        repeat (1100) tick();

        chk(cont_bad == 0, "R10 bus driven only with output enable high", cont_bad, 0);
        chk(win_bad == 0, "R6 load window", win_bad, 0);
        chk(width_bad == 0, "R4 strobe widths", width_bad, 0);
        chk(busy_bad == 0, "R2 busy covers selects", busy_bad, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule